// File: doc/BRIEF.md
# Double Circulant Orthogonality Checker

This block decides whether a candidate built from two circulant matrices is self-orthogonal in the sense needed by a double-circulant code search. The candidate is a `2*W`-bit word. Its lower half is the first row of a `W x W` circulant matrix A and its upper half is the first row of a circulant matrix B. Each following row of a matrix is the row above it rotated right by one column. The block reports whether A·Aᵀ + B·Bᵀ equals the identity matrix, with all arithmetic over GF(2).

A circulant product is itself circulant, so only the first row of the sum needs to be examined. Each entry of that row is the parity of (row 0 AND row k) of A, XORed with the same parity for B. Row k is the base vector rotated left by k bit positions when bit j holds column j. The block compares one entry per clock cycle. It stops on the first entry that is wrong and reports a fail at once. A surviving candidate is reported as a pass after W cycles. A search loop drives a new candidate with a start pulse whenever `busy_o` is low, waits for `done_o`, and reads `pass_o`.

The controller has two states. In IDLE it waits for a start. The IDLE→SCAN transition happens on a start pulse and loads the candidate. SCAN stays in SCAN while entries match and the column index is below W-1. The SCAN→IDLE transition happens on the first mismatch (verdict fail) or after column W-1 matches (verdict pass). The transition pulses `done_o` and updates `pass_o`.

Top module: `dcirc_orth_check`

## Requirements
- R1: With x(k+1) = `cand_i[k]`, matrix A has first row x1..xW taken from `cand_i[W-1:0]`, and B has first row x(W+1)..x(2W) taken from `cand_i[2W-1:W]`. Each later row is the previous row rotated right by one column. `pass_o` is 1 after a decision exactly when A·Aᵀ + B·Bᵀ equals the W×W identity over GF(2).
- R2: A start pulse is accepted on a clock edge where `busy_o` is low. `busy_o` reads 1 from the following cycle until the decision.
- R3: A start pulse while `busy_o` is high is ignored. The verdict and the decision time of the running candidate do not change.
- R4: `done_o` is high for exactly one cycle per accepted candidate, and never at the same time as `busy_o`.
- R5: `pass_o` changes only in a cycle where `done_o` is high, and holds its value until the next decision.
- R6: Let k be the lowest column index whose entry in row 0 of the sum is wrong. `done_o` rises k+1 cycles after the edge that accepted start, with `pass_o` = 0.
- R7: A passing candidate is decided exactly W cycles after the accepting edge.
- R8: After reset, `busy_o`, `done_o` and `pass_o` are all 0.
- R9: The diagonal entry, parity(A row) XOR parity(B row), must be 1. If it is not, the candidate fails at column 0, one cycle after start (for example, the all-zero candidate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept `cand_i` when not busy |
| cand_i | input | 2*W | Candidate: A row in lower half, B row in upper half |
| busy_o | output | 1 | A candidate is being scanned |
| done_o | output | 1 | One-cycle decision strobe |
| pass_o | output | 1 | Verdict of the last decision |

## Verification
The hardest situation to reach is a start pulse that arrives while a long scan is under way. Most candidates fail at column 0, so a scan rarely stays busy long enough for this to happen. The bench therefore first runs a candidate known to pass, such as a single set bit in A with B all zero, which keeps the block busy for the full W cycles. In the middle of that scan it pulses start with a candidate that would fail at once. It then checks that the verdict and the decision time still belong to the first candidate. Early exits at columns other than 0 are reached with sparse patterns such as three adjacent ones. A reference model computes the full matrix product from the row definition to give the expected results.

// File: rtl/dco_pkg.sv
package dco_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } dco_state_t;
endpackage

// File: rtl/dco_lane.sv
module dco_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] vec_i,
    output logic         term_o
);
    logic [W-1:0] base_q;
    logic [W-1:0] rot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            rot_q  <= '0;
        end else if (load_i) begin
            base_q <= vec_i;
            rot_q  <= vec_i;
        end else if (step_i) begin
            rot_q  <= {rot_q[W-2:0], rot_q[W-1]};
        end
    end

    // inner product of row 0 with the current rotated row
    assign term_o = ^(base_q & rot_q);

    assert_load_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (rot_q == base_q));
endmodule

// File: rtl/dco_fsm.sv
module dco_fsm
    import dco_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic entry_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o,
    output logic pass_o
);
    localparam int IDX_W = $clog2(W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(W - 1);

    dco_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              mismatch;
    logic              last_col;

    assign mismatch = entry_i ^ (idx_q == '0);
    assign last_col = (idx_q == LAST);
    assign load_o   = (state_q == ST_IDLE) && start_i;
    assign step_o   = (state_q == ST_SCAN);
    assign busy_o   = (state_q == ST_SCAN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SCAN;
            ST_SCAN: if (mismatch || last_col) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) idx_q <= '0;
                ST_SCAN: begin
                    idx_q <= idx_q + 1'b1;
                    if (mismatch) begin
                        done_o <= 1'b1;
                        pass_o <= 1'b0;
                    end else if (last_col) begin
                        done_o <= 1'b1;
                        pass_o <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> busy_o);
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_pass_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_o) |-> done_o);
    assert_early_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mismatch) |=> (done_o && !pass_o));
    assert_full_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pass_o) |-> ($past(idx_q) == LAST));
endmodule

// File: rtl/dcirc_orth_check.sv
module dcirc_orth_check #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2*W-1:0] cand_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           pass_o
);
    localparam int LANES = 2;

    logic             load;
    logic             step;
    logic [LANES-1:0] term;
    logic             entry;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dco_lane #(.W(W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .step_i (step),
            .vec_i  (cand_i[g*W +: W]),
            .term_o (term[g])
        );
    end

    assign entry = ^term;

    dco_fsm #(.W(W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .entry_i (entry),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .pass_o  (pass_o)
    );

    assert_reset_idle_R8: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !pass_o));
endmodule

// File: tb/sim_dcirc_orth_check.sv
module sim_dcirc_orth_check;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [2*W-1:0] cand_i = '0;
    logic           busy_o, done_o, pass_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dcirc_orth_check #(.W(W)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference: full matrix product from the row definition
    function automatic void ref_eval(input logic [2*W-1:0] c, output bit ok, output int k);
        logic [W-1:0] ra [W];
        logic [W-1:0] rb [W];
        bit e;
        for (int i = 0; i < W; i++)
            for (int j = 0; j < W; j++) begin
                ra[i][j] = c[(j - i + W) % W];
                rb[i][j] = c[W + (j - i + W) % W];
            end
        ok = 1; k = -1;
        for (int i = 0; i < W; i++)
            for (int j = 0; j < W; j++) begin
                e = (^(ra[i] & ra[j])) ^ (^(rb[i] & rb[j]));
                if (e != (i == j)) begin
                    ok = 0;
                    if (i == 0 && k < 0) k = j;
                end
            end
    endfunction

    task automatic run_cand(input logic [2*W-1:0] c, input string tag);
        bit ok; int k; int lat; int exp_lat;
        ref_eval(c, ok, k);
        exp_lat = ok ? W : k + 1;
        @(negedge clk); start_i = 1'b1; cand_i = c;
        @(negedge clk); start_i = 1'b0;
        lat = 0;
        check(busy_o == 1'b1, "R2", int'(busy_o), 1);
        while (!done_o && lat < 100) begin @(negedge clk); lat++; end
        check(pass_o == ok, {"R1 ", tag}, int'(pass_o), int'(ok));
        check(lat == exp_lat, ok ? "R7" : "R6", lat, exp_lat);
        @(negedge clk);
        check(done_o == 1'b0, "R4", int'(done_o), 0);
        check(pass_o == ok, "R5", int'(pass_o), int'(ok));
    endtask

    task automatic t_reset();
        check(!busy_o && !done_o && !pass_o, "R8", int'({busy_o, done_o, pass_o}), 0);
    endtask

    task automatic t_diag();
        run_cand('0, "R9 zero");
        run_cand({32'h1, 32'h1}, "R9 two singles");
    endtask

    task automatic t_busy_ignore();
        int lat = 0;
        @(negedge clk); start_i = 1'b1; cand_i = {32'h0, 32'h0000_0008};
        @(negedge clk); start_i = 1'b0;
        repeat (5) begin @(negedge clk); lat++; end
        start_i = 1'b1; cand_i = '0;
        @(negedge clk); lat++; start_i = 1'b0;
        while (!done_o && lat < 100) begin @(negedge clk); lat++; end
        check(lat == W, "R3 latency", lat, W);
        check(pass_o == 1'b1, "R3 verdict", int'(pass_o), 1);
        @(negedge clk);
        check(busy_o == 1'b0, "R3 no restart", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_cand({32'h0, 32'h1}, "A identity");
        run_cand({32'h0020_0000, 32'h0}, "B permutation");
        run_cand({32'h0, 32'h7}, "three adjacent");
        run_cand({32'h0, 32'h0000_000B}, "sparse A");
        t_diag();
        t_busy_ignore();
        for (int n = 0; n < 8; n++) run_cand({$urandom, $urandom}, "random");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule